// File: doc/BRIEF.md
# Region-Stepping Block Migration Controller

This controller keeps the placement record for blocks in a shared last-level cache split into sixteen regions and serving eight cores. Regions 0 to 7 are the local regions, where region c belongs to core c. Regions 8 to 11 are the inter regions, where inter region 8+k sits next to the local regions of cores 2k and 2k+1. Regions 12 to 15 are the center regions, where center 12+k is the one closest to inter 8+k.

Each accepted request carries a core number and a block address. The low address bits select a tracking slot and the rest form the tag. One cycle after acceptance the controller returns the region where the block now sits. In the same cycle it returns a search mask that covers every region, because the lookup has to be broadcast over the whole bankset. When one core keeps requesting a block, the controller issues a command that moves the block one region toward that core. The command is held until the storage side acknowledges it.

Top module: `regmig_ctrl`

## Requirements
- R1: After synchronous active-low reset the controller shows req_ready high, rsp_valid low, mig_valid low and srch_mask zero, and no slot holds a block.
- R2: A request that finds its slot empty fills the slot. The block's region is the low four tag bits (tag = req_addr[8:3], slot = req_addr[2:0]), and that region is what rsp_region reports one cycle later.
- R3: In the cycle after every accepted request, rsp_valid is 1 and srch_mask is all sixteen ones. In any other cycle both are zero.
- R4: On the third consecutive request from the same core to a block not already in that core's local region, mig_valid rises one cycle later with mig_src equal to the current region. The streak then restarts, so the next move needs three more requests.
- R5: A request from a core other than the last requester restarts the streak at one for the new core.
- R6: The hop table gives the next region for a target core t. A local region c goes to inter 8+c/2. Inter 8+k goes to local t when k equals t/2, and otherwise to center 12+k. Center goes to inter 8+t/2.
- R7: mig_valid, mig_src and mig_dst stay unchanged until mig_ack is high. After the ack edge, mig_valid is low and the block's region is mig_dst.
- R8: While a move is outstanding, req_ready is low for requests to that block's slot, including the cycle in which mig_ack is high. A stalled request produces no response.
- R9: A block that is already in the requester's local region never moves, however long the streak from that core.
- R10: A threshold-reaching request to another block while a move is outstanding, including in the ack cycle, issues no move. It leaves the streak at two, so the next request from the same core issues the move.
- R11: A request whose tag differs from the tag stored in its slot replaces the entry and takes its initial region from its own tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_core | input | 3 | Requesting core |
| req_addr | input | 9 | Block address: tag in [8:3], slot in [2:0] |
| rsp_valid | output | 1 | Response pulse for an accepted request |
| rsp_region | output | 4 | Region holding the block |
| srch_mask | output | 16 | Regions probed by the broadcast lookup |
| mig_valid | output | 1 | Move command outstanding |
| mig_src | output | 4 | Region the block leaves |
| mig_dst | output | 4 | Region the block enters |
| mig_slot | output | 3 | Tracking slot of the moving block |
| mig_ack | input | 1 | Storage side has completed the move |

## Verification
Two events can land on the same edge. One is the acknowledgement of an outstanding move. The other is a request to a different block that completes its streak. The bench raises mig_ack in the same cycle as the third request from core 4 to a second block. It then checks that no command appears after that edge and that the very next request from core 4 does issue one. The bench also holds a request to the moving block's slot across the ack cycle, checks that it is neither accepted nor answered, and then checks that a later request reports the destination region.

// File: rtl/regmig_pkg.sv
// Shared constants for the region migration controller.
// Assumes eight cores and sixteen regions laid out local/inter/center.
package regmig_pkg;
    localparam int NCORE    = 8;
    localparam int CORE_W   = $clog2(NCORE);
    localparam int NREG     = 16;
    localparam int REG_W    = $clog2(NREG);
    localparam int THRESH   = 3;
    localparam int STREAK_W = $clog2(THRESH + 1);
    typedef logic [REG_W-1:0]  region_t;
    typedef logic [CORE_W-1:0] core_t;
endpackage

// File: rtl/regmig_hop.sv
// Next-hop table: given a block's region and the requesting core, returns
// the neighbouring region one step closer to that core's local region.
// Assumes region codes 0-7 local, 8-11 inter, 12-15 center.
module regmig_hop
    import regmig_pkg::*;
(
    input  region_t cur,
    input  core_t   tgt,
    output region_t nxt,
    output logic    at_home
);
    // Decode region class and pick the adjacent region toward tgt.
    always_comb begin
        at_home = 1'b0;
        if (!cur[3]) begin
            at_home = (cur[2:0] == tgt);
            nxt     = {2'b10, cur[2:1]};
        end else if (cur[3:2] == 2'b10) begin
            if (cur[1:0] == tgt[2:1]) nxt = {1'b0, tgt};
            else                      nxt = {2'b11, cur[1:0]};
        end else begin
            nxt = {2'b10, tgt[2:1]};
        end
    end

    // Every non-home step must change region.
    always_comb begin
        AST_HOP_MOVES: assert (at_home || (nxt != cur)); // R6
    end
endmodule

// File: rtl/regmig_store.sv
// Placement table: one entry per slot with valid, tag, region, last core
// and streak. One full write port for requests and one region-only port
// for acknowledged moves; the top guarantees they never hit the same slot.
module regmig_store
    import regmig_pkg::*;
#(
    parameter  int NENT  = 8,
    parameter  int TAG_W = 6,
    localparam int IDX_W = $clog2(NENT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic                rd_valid,
    output logic [TAG_W-1:0]    rd_tag,
    output region_t             rd_region,
    output core_t               rd_last,
    output logic [STREAK_W-1:0] rd_streak,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [TAG_W-1:0]    wr_tag,
    input  region_t             wr_region,
    input  core_t               wr_last,
    input  logic [STREAK_W-1:0] wr_streak,
    input  logic                mv_en,
    input  logic [IDX_W-1:0]    mv_idx,
    input  region_t             mv_region
);
    logic                valid_q  [NENT];
    logic [TAG_W-1:0]    tag_q    [NENT];
    region_t             region_q [NENT];
    core_t               last_q   [NENT];
    logic [STREAK_W-1:0] streak_q [NENT];

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        // Update one entry from the request port or the move port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[e]  <= 1'b0;
                tag_q[e]    <= '0;
                region_q[e] <= '0;
                last_q[e]   <= '0;
                streak_q[e] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                valid_q[e]  <= 1'b1;
                tag_q[e]    <= wr_tag;
                region_q[e] <= wr_region;
                last_q[e]   <= wr_last;
                streak_q[e] <= wr_streak;
            end else if (mv_en && mv_idx == IDX_W'(e)) begin
                region_q[e] <= mv_region;
            end
        end
    end

    // Combinational read of the addressed slot.
    always_comb begin
        rd_valid  = valid_q[rd_idx];
        rd_tag    = tag_q[rd_idx];
        rd_region = region_q[rd_idx];
        rd_last   = last_q[rd_idx];
        rd_streak = streak_q[rd_idx];
    end
endmodule

// File: rtl/regmig_ctrl.sv
// Region migration controller top. Looks up the block, reports its region
// with a full broadcast search mask, counts same-core streaks and issues one
// single-hop move at a time, stalling requests to the block being moved.
// Assumes the storage side raises mig_ack once per command.
module regmig_ctrl
    import regmig_pkg::*;
#(
    parameter  int NENT   = 8,
    parameter  int TAG_W  = 6,
    localparam int IDX_W  = $clog2(NENT),
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CORE_W-1:0] req_core,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [REG_W-1:0]  rsp_region,
    output logic [NREG-1:0]   srch_mask,
    output logic              mig_valid,
    output logic [REG_W-1:0]  mig_src,
    output logic [REG_W-1:0]  mig_dst,
    output logic [IDX_W-1:0]  mig_slot,
    input  logic              mig_ack
);
    logic [IDX_W-1:0]    idx;
    logic [TAG_W-1:0]    tag;
    logic                rd_valid;
    logic [TAG_W-1:0]    rd_tag;
    region_t             rd_region;
    core_t               rd_last;
    logic [STREAK_W-1:0] rd_streak;
    logic                hit, same, reach, accept, fire, at_home;
    region_t             cur_region, nxt_region;
    logic [STREAK_W-1:0] new_streak;

    // Split the address into slot and tag.
    always_comb begin
        idx = req_addr[IDX_W-1:0];
        tag = req_addr[ADDR_W-1:IDX_W];
    end

    regmig_store #(.NENT(NENT), .TAG_W(TAG_W)) store_i (
        .clk(clk), .rst_n(rst_n), .rd_idx(idx),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_region(rd_region),
        .rd_last(rd_last), .rd_streak(rd_streak),
        .wr_en(accept), .wr_idx(idx), .wr_tag(tag), .wr_region(cur_region),
        .wr_last(req_core), .wr_streak(new_streak),
        .mv_en(mig_valid && mig_ack), .mv_idx(mig_slot), .mv_region(mig_dst)
    );

    regmig_hop hop_i (
        .cur(cur_region), .tgt(req_core), .nxt(nxt_region), .at_home(at_home)
    );

    // Stall only requests aimed at the slot whose move is outstanding.
    always_comb req_ready = !(mig_valid && idx == mig_slot);

    // Hit/streak evaluation and move decision for the presented request.
    always_comb begin
        accept     = req_valid && req_ready;
        hit        = rd_valid && (rd_tag == tag);
        cur_region = hit ? rd_region : tag[REG_W-1:0];
        same       = hit && (rd_last == req_core);
        reach      = same && (rd_streak == STREAK_W'(THRESH - 1));
        fire       = accept && reach && !at_home && !mig_valid;
        if (fire)       new_streak = '0;
        else if (reach) new_streak = STREAK_W'(THRESH - 1);
        else if (same)  new_streak = rd_streak + 1'b1;
        else            new_streak = STREAK_W'(1);
    end

    // Registered response and broadcast search mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_region <= '0;
            srch_mask  <= '0;
        end else begin
            rsp_valid  <= accept;
            rsp_region <= accept ? cur_region : rsp_region;
            srch_mask  <= accept ? '1 : '0;
        end
    end

    // Move command register: set on fire, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mig_valid <= 1'b0;
            mig_src   <= '0;
            mig_dst   <= '0;
            mig_slot  <= '0;
        end else if (fire) begin
            mig_valid <= 1'b1;
            mig_src   <= cur_region;
            mig_dst   <= nxt_region;
            mig_slot  <= idx;
        end else if (mig_valid && mig_ack) begin
            mig_valid <= 1'b0;
        end
    end

    AST_MIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mig_valid && !mig_ack |=> mig_valid && $stable(mig_src) && $stable(mig_dst)); // R7
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        mig_valid && mig_ack |=> !mig_valid); // R7
    AST_LOCAL_TO_INTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mig_valid) && !mig_src[3] |-> mig_dst[3:2] == 2'b10); // R6
    AST_MASK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> srch_mask == '1); // R3
    AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> srch_mask == '0); // R3
endmodule

// File: tb/regmig_ctrl_tb_top.sv
`timescale 1ns/1ps
module regmig_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_core = '0;
    logic [8:0] req_addr = '0;
    logic       rsp_valid;
    logic [3:0] rsp_region;
    logic [15:0] srch_mask;
    logic       mig_valid;
    logic [3:0] mig_src, mig_dst;
    logic [2:0] mig_slot;
    logic       mig_ack = 1'b0;
    int n_tests = 0;
    int n_fail  = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    regmig_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_core(req_core), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_region(rsp_region), .srch_mask(srch_mask), .mig_valid(mig_valid),
        .mig_src(mig_src), .mig_dst(mig_dst), .mig_slot(mig_slot), .mig_ack(mig_ack)
    );

    // Vector: core[25:23] addr[22:14] region[13:10] mig[9] src[8:5] dst[4:1] ack[0]
    localparam int NV = 21;
    localparam logic [25:0] VEC [NV] = '{
        {3'd5, 9'd0, 4'd0,  1'b0, 4'd0,  4'd0,  1'b0},  // R2 fill
        {3'd5, 9'd0, 4'd0,  1'b0, 4'd0,  4'd0,  1'b0},
        {3'd5, 9'd0, 4'd0,  1'b1, 4'd0,  4'd8,  1'b1},  // R4 R6 local->inter
        {3'd5, 9'd0, 4'd8,  1'b0, 4'd0,  4'd0,  1'b0},  // R7 region updated
        {3'd5, 9'd0, 4'd8,  1'b0, 4'd0,  4'd0,  1'b0},
        {3'd5, 9'd0, 4'd8,  1'b1, 4'd8,  4'd12, 1'b1},  // R6 inter->center
        {3'd5, 9'd0, 4'd12, 1'b0, 4'd0,  4'd0,  1'b0},
        {3'd5, 9'd0, 4'd12, 1'b0, 4'd0,  4'd0,  1'b0},
        {3'd5, 9'd0, 4'd12, 1'b1, 4'd12, 4'd10, 1'b1},  // R6 center->inter
        {3'd5, 9'd0, 4'd10, 1'b0, 4'd0,  4'd0,  1'b0},
        {3'd5, 9'd0, 4'd10, 1'b0, 4'd0,  4'd0,  1'b0},
        {3'd5, 9'd0, 4'd10, 1'b1, 4'd10, 4'd5,  1'b1},  // R6 inter->local
        {3'd5, 9'd0, 4'd5,  1'b0, 4'd0,  4'd0,  1'b0},  // R9 at home
        {3'd5, 9'd0, 4'd5,  1'b0, 4'd0,  4'd0,  1'b0},
        {3'd5, 9'd0, 4'd5,  1'b0, 4'd0,  4'd0,  1'b0},
        {3'd6, 9'd25, 4'd3, 1'b0, 4'd0,  4'd0,  1'b0},
        {3'd6, 9'd25, 4'd3, 1'b0, 4'd0,  4'd0,  1'b0},
        {3'd2, 9'd25, 4'd3, 1'b0, 4'd0,  4'd0,  1'b0},  // R5 streak broken
        {3'd6, 9'd25, 4'd3, 1'b0, 4'd0,  4'd0,  1'b0},
        {3'd6, 9'd25, 4'd3, 1'b0, 4'd0,  4'd0,  1'b0},
        {3'd6, 9'd25, 4'd3, 1'b1, 4'd3,  4'd9,  1'b1}   // R5 R4 restarted streak
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One accepted request; caller is just after a negedge.
    task automatic do_req(input int core, input int addr, input bit ack,
                          input int exp_reg, input bit exp_mig,
                          input int exp_src, input int exp_dst, input string req);
        req_core  = 3'(core);
        req_addr  = 9'(addr);
        req_valid = 1'b1;
        mig_ack   = ack;
        #1;
        chk(req_ready == 1'b1, {req, " ready"}, int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        mig_ack   = 1'b0;
        chk(rsp_valid == 1'b1 && srch_mask == 16'hFFFF, {req, " R3 rsp/mask"},
            int'(srch_mask), 16'hFFFF);
        chk(rsp_region == 4'(exp_reg), {req, " region"}, int'(rsp_region), exp_reg);
        chk(mig_valid == exp_mig, {req, " mig_valid"}, int'(mig_valid), int'(exp_mig));
        if (exp_mig) begin
            chk(mig_src == 4'(exp_src), {req, " mig_src"}, int'(mig_src), exp_src);
            chk(mig_dst == 4'(exp_dst), {req, " mig_dst"}, int'(mig_dst), exp_dst);
        end
    endtask

    task automatic do_ack(input string req);
        mig_ack = 1'b1;
        @(negedge clk);
        mig_ack = 1'b0;
        chk(mig_valid == 1'b0, {req, " ack clears"}, int'(mig_valid), 0);
        chk(rsp_valid == 1'b0 && srch_mask == 16'h0, {req, " R3 idle mask"},
            int'(srch_mask), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(mig_valid == 1'b0, "R1 mig_valid", int'(mig_valid), 0);
        chk(srch_mask == 16'h0, "R1 mask", int'(srch_mask), 0);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            do_req(int'(v[25:23]), int'(v[22:14]), 1'b0, int'(v[13:10]), v[9],
                   int'(v[8:5]), int'(v[4:1]), $sformatf("vec%0d R4/R6", i));
            if (v[0]) do_ack($sformatf("vec%0d R7", i));
        end

        // R11: different tag in slot 0 replaces the entry.
        do_req(1, (8'h2E << 3), 1'b0, 14, 1'b0, 0, 0, "R11 refill");
        do_req(1, (8'h2E << 3), 1'b0, 14, 1'b0, 0, 0, "R11 kept");

        // Slot 2 (tag 7, local of core 7) pulled by core 0: move 7 -> 11.
        do_req(0, 58, 1'b0, 7, 1'b0, 0, 0, "R4 s2a");
        do_req(0, 58, 1'b0, 7, 1'b0, 0, 0, "R4 s2b");
        do_req(0, 58, 1'b0, 7, 1'b1, 7, 11, "R4 s2c");

        // R8: request to moving slot is stalled.
        req_core = 3'd0; req_addr = 9'd58; req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b0, "R8 stall", int'(req_ready), 0);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 no response", int'(rsp_valid), 0);
        req_valid = 1'b0;

        // Slot 3 (tag 1) by core 4 while the move is outstanding.
        do_req(4, 11, 1'b0, 1, 1'b1, 7, 11, "R10 s3a");
        do_req(4, 11, 1'b0, 1, 1'b1, 7, 11, "R10 s3b");

        // R8 in the ack cycle: moving slot still stalled.
        req_core = 3'd0; req_addr = 9'd58; req_valid = 1'b1; mig_ack = 1'b1;
        #1;
        chk(req_ready == 1'b0, "R8 stall in ack cycle", int'(req_ready), 0);
        req_valid = 1'b0; mig_ack = 1'b0;
        #1;

        // R10: threshold reached on the ack edge -> no move issued.
        do_req(4, 11, 1'b1, 1, 1'b0, 0, 0, "R10 deferred on ack");
        do_req(4, 11, 1'b0, 1, 1'b1, 1, 8, "R10 retry issues");
        do_ack("R10");

        // R7: region of slot 2 is the destination of its acknowledged move.
        do_req(0, 58, 1'b0, 11, 1'b0, 0, 0, "R7 region after ack");

        @(negedge clk);
        chk(rsp_valid == 1'b0 && srch_mask == 16'h0, "R3 idle", int'(srch_mask), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule